// File: doc/BRIEF.md
# SDRAM Command Decoder with Data-Mask Pipeline

This block sits on the memory-device side of a single-data-rate SDRAM interface. On every rising clock edge it samples the control strobes (chip select, row strobe, column strobe, write enable and clock enable), the bank bits, the address bus and the data mask. It turns the pin pattern into a command code and keeps the open row of each of four banks. It also keeps a refresh row counter and a shadow copy of the mode op-code.

Alongside the decode, the block produces one data-enable strobe for write beats and one for read beats. The burst length is fixed. Read data follows a two-cycle column latency. The data mask hides a write beat in the cycle where it is sampled, and it hides a read beat two cycles after it is sampled. A downstream array model or a protocol monitor uses these strobes and the decoded fields.

All outputs are registered. The values sampled at edge N show up at the outputs just after edge N. The active-low strobes are written with an `N` suffix: 1 means high (inactive) and 0 means low (asserted).

Top module: `sdram_cmd_decoder`

## Requirements
- R1: With csN = 1 the cycle decodes as inhibit (code 0) whatever the other pins hold. It changes no bank, refresh or mode state.
- R2: With csN = 0, {rasN,casN,weN} decodes as follows: 111 gives NOP (code 1), 011 gives ACTIVE (2), 101 gives READ (3), 100 gives WRITE (4), 110 gives burst stop (5), 010 gives PRECHARGE (6), 001 with cke = 1 gives auto refresh (7), 001 with cke = 0 gives self-refresh entry (8), and 000 gives load mode (9). For ACTIVE, READ, WRITE and single-bank PRECHARGE, cmdBank is the sampled bank. For any other command it is 0.
- R3: ACTIVE sets bankOpen[ba] and stores addr[11:0] as that bank's row. cmdRow reports that row.
- R4: READ and WRITE report the column from addr[7:0] on cmdCol, report the row last stored for that bank on cmdRow, and set autoPre to addr[10]. When addr[10] = 1, the bank's open bit clears at the same edge.
- R5: PRECHARGE with addr[10] = 0 clears only bankOpen[ba]. With addr[10] = 1 it clears all four bits, raises preAll, ignores ba and reports cmdBank = 0.
- R6: Both refresh commands ignore ba, addr and dqm. They report the internal refresh row on cmdRow and cmdBank = 0.
- R7: The 12-bit refresh row increments by one after each auto refresh and wraps from 4095 to 0. Self-refresh entry leaves it unchanged.
- R8: Load mode copies addr[11:0] into modeReg.
- R9: A WRITE at cycle t makes cycles t to t+3 write beats. wrDataEn for beat cycle c is 1 unless dqm was 1 in cycle c.
- R10: A READ at cycle t makes cycles t+2 to t+5 read beats. A new READ replaces any earlier read beats after t+1. rdDataEn for beat cycle c is 1 unless dqm was 1 in cycle c-2.
- R11: A burst stop in cycle b ends the write burst before b, and a READ also ends the write burst in its own cycle. The burst stop also cancels read beats later than b+1.
- R12: A READ or WRITE to a bank whose open bit is clear raises bankErr for that cycle.
- R13: While synchronous active-high rst is 1, all bank state, rows, refresh row, mode shadow, bursts and the mask pipeline clear. The outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable (chooses between the two refresh kinds) |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bus |
| dqm | input | 1 | Data mask |
| cmdCode | output | 4 | Decoded command code |
| cmdBank | output | 2 | Bank of the decoded command |
| cmdRow | output | 12 | Row of the access or refresh |
| cmdCol | output | 8 | Column of a READ or WRITE |
| autoPre | output | 1 | Auto precharge requested |
| preAll | output | 1 | All banks precharged |
| bankErr | output | 1 | Access to a closed bank |
| bankOpen | output | 4 | Open flag per bank |
| refreshRow | output | 12 | Internal refresh row counter |
| modeReg | output | 12 | Mode op-code shadow |
| wrDataEn | output | 1 | Write beat enabled |
| rdDataEn | output | 1 | Read beat enabled |

## Verification
The single mask pin serves two timings at once. In one cycle it can hide a write beat straight away and also mark the read beat two cycles ahead. The bench provokes this by placing a WRITE, with the mask high, inside the latency window of an earlier READ. The read and write beats then overlap, and a masked write beat coincides with a read beat whose own mask was sampled earlier. The behavioural model keeps a per-cycle mask history and separate beat windows. It judges wrDataEn and rdDataEn on every clock against that history, so a mix-up between the zero-cycle and two-cycle paths shows up as a mismatch.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  typedef enum logic [3:0] {
    CMD_INHIBIT   = 4'd0,
    CMD_NOP       = 4'd1,
    CMD_ACTIVE    = 4'd2,
    CMD_READ      = 4'd3,
    CMD_WRITE     = 4'd4,
    CMD_BST       = 4'd5,
    CMD_PRECHARGE = 4'd6,
    CMD_AREF      = 4'd7,
    CMD_SREF      = 4'd8,
    CMD_LMR       = 4'd9
  } cmd_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    cmd_e code;
    logic act;
    logic rd;
    logic wr;
    logic bst;
    logic pre;     // single-bank precharge
    logic preAll;  // precharge of every bank
    logic aref;
    logic sref;
    logic lmr;
    logic apFlag;  // auto precharge on this column access
    logic wrBeat;  // current cycle carries a write beat
    logic rdBeat;  // current cycle carries a read beat
  } strobe_t;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int BURST_LEN = 4   // at least 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    csN,
  input  logic    rasN,
  input  logic    casN,
  input  logic    weN,
  input  logic    cke,
  input  logic    apBit,
  output strobe_t stb
);

  localparam int WR_W = BURST_LEN - 1;   // beats after the WRITE cycle
  localparam int RD_W = BURST_LEN + 1;   // latency slot plus read beats

  cmd_e code;
  logic [WR_W-1:0] wrSched;
  logic [RD_W-1:0] rdSched;
  logic [RD_W-1:0] rdShift;

  always_comb begin
    code = CMD_INHIBIT;
    if (!csN) begin
      unique case ({rasN, casN, weN})
        3'b111:  code = CMD_NOP;
        3'b011:  code = CMD_ACTIVE;
        3'b101:  code = CMD_READ;
        3'b100:  code = CMD_WRITE;
        3'b110:  code = CMD_BST;
        3'b010:  code = CMD_PRECHARGE;
        3'b001:  code = cke ? CMD_AREF : CMD_SREF;
        default: code = CMD_LMR;
      endcase
    end
  end

  always_comb begin
    stb.code   = code;
    stb.act    = (code == CMD_ACTIVE);
    stb.rd     = (code == CMD_READ);
    stb.wr     = (code == CMD_WRITE);
    stb.bst    = (code == CMD_BST);
    stb.pre    = (code == CMD_PRECHARGE) && !apBit;
    stb.preAll = (code == CMD_PRECHARGE) && apBit;
    stb.aref   = (code == CMD_AREF);
    stb.sref   = (code == CMD_SREF);
    stb.lmr    = (code == CMD_LMR);
    stb.apFlag = apBit;
    stb.wrBeat = (code == CMD_WRITE) ||
                 (wrSched[0] && (code != CMD_BST) && (code != CMD_READ));
    stb.rdBeat = rdSched[0];
  end

  assign rdShift = rdSched >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSched <= '0;
      rdSched <= '0;
    end else begin
      if (stb.wr)
        wrSched <= '1;
      else if (stb.bst || stb.rd)
        wrSched <= '0;
      else
        wrSched <= wrSched >> 1;

      if (stb.rd)
        rdSched <= {{BURST_LEN{1'b1}}, rdShift[0]};
      else if (stb.bst)
        rdSched <= {{BURST_LEN{1'b0}}, rdShift[0]};
      else
        rdSched <= rdShift;
    end
  end

  // R11: a burst stop leaves no read beat two cycles later
  p_bst_cut_r11: assert property (@(posedge clk) disable iff (rst)
    stb.bst |=> ##1 !stb.rdBeat);

  // R11: no write beat is reported in a burst-stop cycle
  p_bst_nowr_r11: assert property (@(posedge clk) disable iff (rst)
    stb.bst |-> !stb.wrBeat);

endmodule

// File: rtl/sdram_cmd_datapath.sv
module sdram_cmd_datapath
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  input  logic              dqm,
  output logic [3:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              autoPre,
  output logic              preAll,
  output logic              bankErr,
  output logic [(1<<BANK_W)-1:0] bankOpen,
  output logic [ROW_W-1:0]  refreshRow,
  output logic [ROW_W-1:0]  modeReg,
  output logic              wrDataEn,
  output logic              rdDataEn
);

  localparam int NUM_BANKS = 1 << BANK_W;
  localparam int RD_MASK_LAT = 2;

  logic [ROW_W-1:0] bankRow [NUM_BANKS];
  logic [ROW_W-1:0] selRow;
  logic             selOpen;
  logic             colCmd;
  logic [RD_MASK_LAT-1:0] dqmPipe;

  assign colCmd = stb.rd || stb.wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             flagQ;
    logic [ROW_W-1:0] rowQ;
    logic             hit;

    assign hit = (ba == BANK_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        flagQ <= 1'b0;
        rowQ  <= '0;
      end else if (stb.act && hit) begin
        flagQ <= 1'b1;
        rowQ  <= addr;
      end else if (stb.preAll || (stb.pre && hit) ||
                   (colCmd && stb.apFlag && hit)) begin
        flagQ <= 1'b0;
      end
    end

    assign bankOpen[b] = flagQ;
    assign bankRow[b]  = rowQ;
  end

  assign selRow  = bankRow[ba];
  assign selOpen = bankOpen[ba];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdCode    <= CMD_INHIBIT;
      cmdBank    <= '0;
      cmdRow     <= '0;
      cmdCol     <= '0;
      autoPre    <= 1'b0;
      preAll     <= 1'b0;
      bankErr    <= 1'b0;
      refreshRow <= '0;
      modeReg    <= '0;
      dqmPipe    <= '0;
      wrDataEn   <= 1'b0;
      rdDataEn   <= 1'b0;
    end else begin
      cmdCode <= stb.code;
      cmdBank <= (stb.act || colCmd || stb.pre) ? ba : '0;
      if (stb.act)
        cmdRow <= addr;
      else if (colCmd)
        cmdRow <= selRow;
      else if (stb.aref || stb.sref)
        cmdRow <= refreshRow;
      else
        cmdRow <= '0;
      cmdCol  <= colCmd ? addr[COL_W-1:0] : '0;
      autoPre <= colCmd && stb.apFlag;
      preAll  <= stb.preAll;
      bankErr <= colCmd && !selOpen;
      if (stb.aref)
        refreshRow <= refreshRow + 1'b1;
      if (stb.lmr)
        modeReg <= addr;
      dqmPipe  <= {dqmPipe[RD_MASK_LAT-2:0], dqm};
      wrDataEn <= stb.wrBeat && !dqm;
      rdDataEn <= stb.rdBeat && !dqmPipe[RD_MASK_LAT-1];
    end
  end

  // R5: precharge-all leaves every bank closed
  p_preall_closed_r5: assert property (@(posedge clk) disable iff (rst)
    stb.preAll |=> (bankOpen == '0));

  // R7: auto refresh advances the row by one, wrapping
  p_refresh_step_r7: assert property (@(posedge clk) disable iff (rst)
    stb.aref |=> (refreshRow == ROW_W'($past(refreshRow) + 1'b1)));

  // R7: self-refresh entry holds the row
  p_sref_hold_r7: assert property (@(posedge clk) disable iff (rst)
    stb.sref |=> $stable(refreshRow));

  // R9: write mask acts in its own cycle
  p_wr_mask_r9: assert property (@(posedge clk) disable iff (rst)
    dqm |=> !wrDataEn);

  // R10: read mask acts two cycles later
  p_rd_mask_r10: assert property (@(posedge clk) disable iff (rst)
    dqm |=> ##2 !rdDataEn);

  // R12: error only on column commands
  p_err_col_r12: assert property (@(posedge clk) disable iff (rst)
    bankErr |-> (cmdCode == CMD_READ || cmdCode == CMD_WRITE));

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 12,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 10,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic [BANK_W-1:0] ba,
  input  logic [ROW_W-1:0]  addr,
  input  logic              dqm,
  output logic [3:0]        cmdCode,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              autoPre,
  output logic              preAll,
  output logic              bankErr,
  output logic [(1<<BANK_W)-1:0] bankOpen,
  output logic [ROW_W-1:0]  refreshRow,
  output logic [ROW_W-1:0]  modeReg,
  output logic              wrDataEn,
  output logic              rdDataEn
);

  strobe_t stb;

  sdram_cmd_ctrl #(.BURST_LEN(BURST_LEN)) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .csN   (csN),
    .rasN  (rasN),
    .casN  (casN),
    .weN   (weN),
    .cke   (cke),
    .apBit (addr[AP_BIT]),
    .stb   (stb)
  );

  sdram_cmd_datapath #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
  ) i_datapath (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .ba         (ba),
    .addr       (addr),
    .dqm        (dqm),
    .cmdCode    (cmdCode),
    .cmdBank    (cmdBank),
    .cmdRow     (cmdRow),
    .cmdCol     (cmdCol),
    .autoPre    (autoPre),
    .preAll     (preAll),
    .bankErr    (bankErr),
    .bankOpen   (bankOpen),
    .refreshRow (refreshRow),
    .modeReg    (modeReg),
    .wrDataEn   (wrDataEn),
    .rdDataEn   (rdDataEn)
  );

  // R1: deselected cycles decode as inhibit
  p_inhibit_r1: assert property (@(posedge clk) disable iff (rst)
    csN |=> (cmdCode == CMD_INHIBIT));

  // R1: deselected cycles leave the mode shadow alone
  p_inhibit_mode_r1: assert property (@(posedge clk) disable iff (rst)
    csN |=> $stable(modeReg));

endmodule

// File: tb/test_sdram_cmd_decoder.sv
`timescale 1ns/1ps
module test_sdram_cmd_decoder;

  localparam int BL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1, dqm = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [3:0]  cmdCode;
  logic [1:0]  cmdBank;
  logic [11:0] cmdRow;
  logic [7:0]  cmdCol;
  logic        autoPre, preAll, bankErr, wrDataEn, rdDataEn;
  logic [3:0]  bankOpen;
  logic [11:0] refreshRow, modeReg;

  always #2 clk = ~clk;

  sdram_cmd_decoder i_sdram_cmd_decoder (
    .clk(clk), .rst(rst), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .ba(ba), .addr(addr), .dqm(dqm),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .autoPre(autoPre), .preAll(preAll), .bankErr(bankErr), .bankOpen(bankOpen),
    .refreshRow(refreshRow), .modeReg(modeReg),
    .wrDataEn(wrDataEn), .rdDataEn(rdDataEn)
  );

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  // reference state
  int  cyc = 0;
  bit  mOpen [4];
  logic [11:0] mRow [4];
  logic [11:0] mRef = '0, mMode = '0;
  int  wrUntil = -100;
  bit  rdMap [int];
  bit  dqmHist [int];
  bit  lastRst = 1;

  // expected outputs
  int  eCode;
  logic [1:0] eBank;
  logic [11:0] eRow;
  logic [7:0] eCol;
  bit  eAp, ePreAll, eErr, eWr, eRd;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model();
    bit isRd, isWr, isBst, wrCur, rdCur, d2;
    int code;
    if (rst) begin
      for (int b = 0; b < 4; b++) begin mOpen[b] = 0; mRow[b] = '0; end
      mRef = '0; mMode = '0; wrUntil = -100;
      rdMap.delete(); dqmHist.delete();
      eCode = 0; eBank = '0; eRow = '0; eCol = '0;
      eAp = 0; ePreAll = 0; eErr = 0; eWr = 0; eRd = 0;
      lastRst = 1;
      cyc++;
      return;
    end
    lastRst = 0;
    if (csN) code = 0;
    else begin
      case ({rasN, casN, weN})
        3'b111: code = 1;
        3'b011: code = 2;
        3'b101: code = 3;
        3'b100: code = 4;
        3'b110: code = 5;
        3'b010: code = 6;
        3'b001: code = cke ? 7 : 8;
        default: code = 9;
      endcase
    end
    isRd = (code == 3); isWr = (code == 4); isBst = (code == 5);
    eCode = code;
    eBank = (code == 2 || code == 3 || code == 4 || (code == 6 && !addr[10])) ? ba : 2'd0;
    eRow = '0; eCol = '0; eAp = 0; ePreAll = 0; eErr = 0;
    case (code)
      2: begin eRow = addr; mOpen[ba] = 1; mRow[ba] = addr; end
      3, 4: begin
        eRow = mRow[ba]; eCol = addr[7:0]; eAp = addr[10];
        eErr = !mOpen[ba];
        if (addr[10]) mOpen[ba] = 0;
      end
      6: begin
        if (addr[10]) begin ePreAll = 1; for (int b = 0; b < 4; b++) mOpen[b] = 0; end
        else mOpen[ba] = 0;
      end
      7: begin eRow = mRef; mRef = mRef + 12'd1; end
      8: eRow = mRef;
      9: mMode = addr;
      default: ;
    endcase
    // write beats
    wrCur = isWr || (cyc <= wrUntil && !isBst && !isRd);
    if (isWr) wrUntil = cyc + BL - 1;
    else if (isBst || isRd) wrUntil = cyc - 1;
    // read beats
    rdCur = rdMap.exists(cyc) ? rdMap[cyc] : 0;
    if (isRd) begin
      for (int j = cyc + 2; j < cyc + 2 * BL + 4; j++) rdMap[j] = 0;
      for (int j = cyc + 2; j <= cyc + 1 + BL; j++) rdMap[j] = 1;
    end else if (isBst) begin
      for (int j = cyc + 2; j < cyc + 2 * BL + 4; j++) rdMap[j] = 0;
    end
    d2 = dqmHist.exists(cyc - 2) ? dqmHist[cyc - 2] : 0;
    dqmHist[cyc] = dqm;
    eWr = wrCur && !dqm;
    eRd = rdCur && !d2;
    cyc++;
  endtask

  task automatic compareAll();
    string p;
    p = lastRst ? "R13 " : "";
    chk({p, "R1/R2 cmdCode"}, cmdCode, eCode);
    chk({p, "R2/R5/R6 cmdBank"}, cmdBank, eBank);
    chk({p, "R3/R4/R6 cmdRow"}, cmdRow, eRow);
    chk({p, "R4 cmdCol"}, cmdCol, eCol);
    chk({p, "R4 autoPre"}, autoPre, eAp);
    chk({p, "R5 preAll"}, preAll, ePreAll);
    chk({p, "R12 bankErr"}, bankErr, eErr);
    chk({p, "R3/R4/R5 bankOpen"}, bankOpen, {mOpen[3], mOpen[2], mOpen[1], mOpen[0]});
    chk({p, "R7 refreshRow"}, refreshRow, mRef);
    chk({p, "R8 modeReg"}, modeReg, mMode);
    chk({p, "R9/R11 wrDataEn"}, wrDataEn, eWr);
    chk({p, "R10/R11 rdDataEn"}, rdDataEn, eRd);
  endtask

  // one clock with the given pins; pattern = {rasN,casN,weN}
  task automatic step(bit r, bit cs, logic [2:0] pat, bit ck,
                      logic [1:0] b, logic [11:0] a, bit m);
    rst = r; csN = cs; {rasN, casN, weN} = pat; cke = ck;
    ba = b; addr = a; dqm = m;
    model();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic nop(bit m); step(0, 0, 3'b111, 1, 2'd0, 12'h000, m); endtask

  localparam logic [2:0] P_NOP = 3'b111, P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_BST = 3'b110, P_PRE = 3'b010, P_REF = 3'b001, P_LMR = 3'b000;

  initial begin
    @(negedge clk);
    // R13: reset state
    repeat (3) step(1, 0, P_LMR, 1, 2'd3, 12'hFFF, 1);
    chk("R13 bankOpen after reset", bankOpen, 4'h0);

    // R8: load mode
    step(0, 0, P_LMR, 1, 2'd2, 12'h033, 0);
    chk("R8 modeReg load", modeReg, 12'h033);
    // R1: deselected load-mode and activate patterns do nothing
    step(0, 1, P_LMR, 1, 2'd1, 12'h7FF, 0);
    step(0, 1, P_ACT, 1, 2'd1, 12'h123, 1);
    chk("R1 modeReg kept", modeReg, 12'h033);
    chk("R1 bank untouched", bankOpen, 4'h0);

    // R3: open banks 1 and 2
    step(0, 0, P_ACT, 1, 2'd1, 12'h2A5, 0);
    step(0, 0, P_ACT, 1, 2'd2, 12'h0F0, 0);
    chk("R3 two banks open", bankOpen, 4'h6);

    // R9/R10 coincidence: READ, then WRITE with dqm high in its latency window
    step(0, 0, P_RD, 1, 2'd1, 12'h012, 0);
    nop(0);
    nop(1);
    step(0, 0, P_WR, 1, 2'd2, 12'h034, 1);
    nop(0);
    nop(1);
    repeat (4) nop(0);

    // R12: read from closed bank 0
    step(0, 0, P_RD, 1, 2'd0, 12'h001, 0);
    chk("R12 closed bank error", bankErr, 1'b1);

    // R4: write with auto precharge closes bank 2
    step(0, 0, P_WR, 1, 2'd2, 12'h4AB, 0);
    chk("R4 auto precharge closes", bankOpen, 4'h2);
    repeat (4) nop(0);

    // R11: burst stop in the middle of a read and of a write
    step(0, 0, P_RD, 1, 2'd1, 12'h020, 0);
    nop(0); nop(0);
    step(0, 0, P_BST, 1, 2'd0, 12'h000, 0);
    repeat (4) nop(0);
    step(0, 0, P_WR, 1, 2'd1, 12'h021, 0);
    nop(0);
    step(0, 0, P_BST, 1, 2'd0, 12'h000, 0);
    repeat (3) nop(0);

    // R5: single precharge, then precharge-all with junk bank bits
    step(0, 0, P_ACT, 1, 2'd3, 12'h555, 0);
    step(0, 0, P_PRE, 1, 2'd1, 12'h000, 0);
    chk("R5 single precharge", bankOpen, 4'h8);
    step(0, 0, P_ACT, 1, 2'd0, 12'h111, 0);
    step(0, 0, P_PRE, 1, 2'd2, 12'h400, 0);
    chk("R5 precharge all", bankOpen, 4'h0);

    // R6/R7: refresh kinds with junk on the other pins
    step(0, 0, P_REF, 1, 2'd3, 12'hABC, 1);
    step(0, 0, P_REF, 0, 2'd1, 12'h456, 0);
    chk("R7 self refresh holds", refreshRow, 12'd1);
    for (int i = 0; i < 4096; i++) step(0, 0, P_REF, 1, 2'(i), 12'(i * 7), 0);
    chk("R7 wrap", refreshRow, 12'd1);

    // mixed stimulus
    for (int i = 0; i < 800; i++) begin
      int k;
      k = $urandom_range(0, 19);
      case (k)
        0:      step(0, 1, 3'($urandom), 1'($urandom), 2'($urandom), 12'($urandom), 1'($urandom));
        1, 2, 3: step(0, 0, P_ACT, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        4, 5, 6: step(0, 0, P_RD, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        7, 8, 9: step(0, 0, P_WR, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        10:     step(0, 0, P_BST, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        11:     step(0, 0, P_PRE, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        12:     step(0, 0, P_REF, 1'($urandom), 2'($urandom), 12'($urandom), 1'($urandom));
        13:     step(0, 0, P_LMR, 1, 2'($urandom), 12'($urandom), 1'($urandom));
        default: nop(1'($urandom));
      endcase
    end

    // R13: reset in the middle of activity
    step(0, 0, P_ACT, 1, 2'd1, 12'h0AA, 0);
    step(0, 0, P_RD, 1, 2'd1, 12'h001, 0);
    step(1, 0, P_NOP, 1, 2'd0, 12'h000, 0);
    chk("R13 reset clears refresh", refreshRow, 12'd0);
    repeat (6) nop(0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule